// File: doc/BRIEF.md
# Mailbox RPC framer

The framer moves one remote-procedure-call message out through a four-register hardware mailbox and, unless told otherwise, collects the reply through the same mailbox. The request sits in a buffer owned by the caller. Its first word is a header that holds the total word count. The engine reads the buffer one word at a time through a combinational read port. Before each word moves, it waits for the target mailbox register to signal empty (transmit) or full (receive). Word k of a message always uses register k modulo the register count, so the header always uses register 0.

On the reply side, received words go back into the caller's buffer through a write port, starting at slot 0. The engine checks the header length on both sides. Every single wait is bounded by a cycle-count timeout. A call ends with a one-cycle done pulse, a 2-bit error code and an 8-bit result byte taken from the first payload word. A caller that expects no answer sets the no-response option, and the call then ends after the last request word.

Top module: `mbx_rpc_framer`

## Requirements
- R1: After reset the engine is idle: busy, done, both mailbox strobes and the buffer write enable are low, and err is 0.
- R2: Message word k (header is k=0) is transferred through mailbox register k mod 4, in increasing k, on both transmit and receive. The selected register appears on mb_tx_sel / mb_rx_sel. Received word k is written to buffer slot k.
- R3: The word count of a message is header bits 15:8. A count of 0 or 1 means the header alone is transferred.
- R4: On transmit, a count above MAX_WORDS ends the call with err = 1 (invalid length) and no mailbox write. A count equal to MAX_WORDS is sent in full.
- R5: On receive, a header whose count exceeds MAX_WORDS is stored into buffer slot 0 as zero. The call then ends with err = 1, and no further mailbox word is read.
- R6: A word is written only while the selected register's empty flag is set, and read only while its full flag is set. While the flag is clear the engine holds the word.
- R7: If the awaited flag stays clear for TIMEOUT_CYCLES consecutive cycles, the call ends with err = 2 (timeout) and no more words move.
- R8: With no_resp = 1 only the transmit phase runs. With no_resp = 0 the receive phase starts right after the last request word.
- R9: busy is high from the cycle after an accepted start until the end of the call. done is high for exactly one cycle per call. err and result hold until the next start, and err = 0 means success.
- R10: result is bits 7:0 of word 1 of the reply, or of the request when no_resp = 1. It is 0 when that message carries only its header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a call (accepted while idle) |
| no_resp | input | 1 | Skip the reply phase for this call |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle end-of-call pulse |
| err | output | 2 | 0 ok, 1 invalid length, 2 timeout |
| result | output | 8 | Result byte of the call |
| buf_rd_idx | output | IDX_W | Buffer slot read for transmit |
| buf_rd_data | input | 32 | Word at buf_rd_idx (combinational) |
| buf_wr_en | output | 1 | Store a received word |
| buf_wr_idx | output | IDX_W | Slot for the received word |
| buf_wr_data | output | 32 | Received word |
| mb_tx_empty | input | 4 | Per-register transmit empty flags |
| mb_tx_we | output | 1 | Write strobe to the selected transmit register |
| mb_tx_sel | output | 2 | Selected transmit register |
| mb_tx_data | output | 32 | Word written to the mailbox |
| mb_rx_full | input | 4 | Per-register receive full flags |
| mb_rx_re | output | 1 | Read strobe from the selected receive register |
| mb_rx_sel | output | 2 | Selected receive register |
| mb_rx_data | input | 32 | Content of the selected receive register |

## Verification
The bench targets the register wrap after the fourth word. A framer that indexed lanes wrongly would put word 4 on register 0 only by accident, or would read a reply out of order. It also tests the length boundaries: count 0, count equal to MAX_WORDS and MAX_WORDS+1 on transmit, and an oversized reply header. An off-by-one comparison there would either drop a legal message or write words it should have refused, and a wrong receive path would leave the bad header in the buffer. Stalled and missing flags check that a word is never pushed into a full register, that the timeout fires after the configured window and not before, and that a no-response call never touches the receive side.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TX_LEN  = 3'd1,
    ST_TX_WAIT = 3'd2,
    ST_RX_WAIT = 3'd3,
    ST_DONE    = 3'd4
  } mbx_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_LEN  = 2'd1,
    ERR_TMO  = 2'd2
  } mbx_err_e;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mbx_lane_pick.sv
module mbx_lane_pick #(
  parameter int NUM_LANES = 4,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic [NUM_LANES-1:0] flags,
  input  logic [LANE_W-1:0]    sel,
  output logic                 hit
);

  logic [NUM_LANES-1:0] sel_oh;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_dec
    assign sel_oh[g] = (sel == LANE_W'(g));
  end

  assign hit = |(flags & sel_oh);

endmodule

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == CW'(LIMIT - 1));
  assign cnt_en  = clr || (run && !expired);

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 4,
  parameter int MAX_WORDS = 8,
  parameter int SIZE_LSB  = 8,
  parameter int SIZE_W    = 8,
  parameter int RES_W     = 8,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int IDX_RAW = $clog2(MAX_WORDS + 1),
  localparam int IDX_W = (IDX_RAW > LANE_W) ? IDX_RAW : LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              no_resp,
  input  logic [DATA_W-1:0] buf_rd_data,
  input  logic [DATA_W-1:0] mb_rx_data,
  input  logic              tx_hit,
  input  logic              rx_hit,
  input  logic              tmo,
  output logic [IDX_W-1:0]  word_idx,
  output logic [LANE_W-1:0] lane,
  output logic              tx_we,
  output logic              rx_re,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              waiting,
  output logic              xfer,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic [RES_W-1:0]  result
);

  mbx_state_e          state_q, state_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [IDX_W-1:0]    tot_q, tot_d;
  logic                nores_q, nores_d;
  mbx_err_e            err_q, err_d;
  logic [RES_W-1:0]    res_q, res_d;

  logic [SIZE_W-1:0]   tx_size;
  logic [SIZE_W-1:0]   rx_size;
  logic                tx_size_bad;
  logic                rx_size_bad;
  logic                last_word;
  logic [IDX_W-1:0]    idx_inc;

  function automatic logic [IDX_W-1:0] words_of(input logic [SIZE_W-1:0] s);
    if (s == '0) begin
      return IDX_W'(1);
    end
    return IDX_W'(s);
  endfunction

  assign tx_size     = buf_rd_data[SIZE_LSB +: SIZE_W];
  assign rx_size     = mb_rx_data[SIZE_LSB +: SIZE_W];
  assign tx_size_bad = (32'(tx_size) > MAX_WORDS);
  assign rx_size_bad = (32'(rx_size) > MAX_WORDS);
  assign idx_inc     = idx_q + IDX_W'(1);
  assign last_word   = (idx_inc == tot_q);

  // next-state and output decode
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tot_d   = tot_q;
    nores_d = nores_q;
    err_d   = err_q;
    res_d   = res_q;
    tx_we   = 1'b0;
    rx_re   = 1'b0;
    wr_en   = 1'b0;
    wr_data = mb_rx_data;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          idx_d   = '0;
          err_d   = ERR_NONE;
          res_d   = '0;
          nores_d = no_resp;
          state_d = ST_TX_LEN;
        end
      end

      ST_TX_LEN: begin
        if (tx_size_bad) begin
          err_d   = ERR_LEN;
          state_d = ST_DONE;
        end else begin
          tot_d   = words_of(tx_size);
          state_d = ST_TX_WAIT;
        end
      end

      ST_TX_WAIT: begin
        if (tx_hit) begin
          tx_we = 1'b1;
          if (idx_q == IDX_W'(1)) begin
            res_d = buf_rd_data[RES_W-1:0];
          end
          if (last_word) begin
            idx_d = '0;
            if (nores_q) begin
              state_d = ST_DONE;
            end else begin
              res_d   = '0;
              state_d = ST_RX_WAIT;
            end
          end else begin
            idx_d = idx_inc;
          end
        end else if (tmo) begin
          err_d   = ERR_TMO;
          state_d = ST_DONE;
        end
      end

      ST_RX_WAIT: begin
        if (rx_hit) begin
          rx_re = 1'b1;
          wr_en = 1'b1;
          if (idx_q == '0) begin
            if (rx_size_bad) begin
              wr_data = '0;
              err_d   = ERR_LEN;
              state_d = ST_DONE;
            end else begin
              tot_d = words_of(rx_size);
              if (words_of(rx_size) == IDX_W'(1)) begin
                state_d = ST_DONE;
              end else begin
                idx_d = IDX_W'(1);
              end
            end
          end else begin
            if (idx_q == IDX_W'(1)) begin
              res_d = mb_rx_data[RES_W-1:0];
            end
            if (last_word) begin
              state_d = ST_DONE;
            end else begin
              idx_d = idx_inc;
            end
          end
        end else if (tmo) begin
          err_d   = ERR_TMO;
          state_d = ST_DONE;
        end
      end

      ST_DONE: begin
        state_d = ST_IDLE;
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tot_q   <= '0;
      nores_q <= 1'b0;
      err_q   <= ERR_NONE;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tot_q   <= tot_d;
      nores_q <= nores_d;
      err_q   <= err_d;
      res_q   <= res_d;
    end
  end

  assign word_idx = idx_q;
  assign lane     = idx_q[LANE_W-1:0];
  assign waiting  = (state_q == ST_TX_WAIT) || (state_q == ST_RX_WAIT);
  assign xfer     = tx_we || rx_re;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign err      = err_q;
  assign result   = res_q;

endmodule

// File: rtl/mbx_rpc_framer.sv
module mbx_rpc_framer #(
  parameter int DATA_W         = 32,
  parameter int NUM_LANES      = 4,
  parameter int MAX_WORDS      = 8,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int SIZE_LSB       = 8,
  parameter int SIZE_W         = 8,
  parameter int RES_W          = 8,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int IDX_RAW = $clog2(MAX_WORDS + 1),
  localparam int IDX_W = (IDX_RAW > LANE_W) ? IDX_RAW : LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 no_resp,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           err,
  output logic [RES_W-1:0]     result,
  output logic [IDX_W-1:0]     buf_rd_idx,
  input  logic [DATA_W-1:0]    buf_rd_data,
  output logic                 buf_wr_en,
  output logic [IDX_W-1:0]     buf_wr_idx,
  output logic [DATA_W-1:0]    buf_wr_data,
  input  logic [NUM_LANES-1:0] mb_tx_empty,
  output logic                 mb_tx_we,
  output logic [LANE_W-1:0]    mb_tx_sel,
  output logic [DATA_W-1:0]    mb_tx_data,
  input  logic [NUM_LANES-1:0] mb_rx_full,
  output logic                 mb_rx_re,
  output logic [LANE_W-1:0]    mb_rx_sel,
  input  logic [DATA_W-1:0]    mb_rx_data
);

  logic              rst_core_n;
  logic              tx_hit;
  logic              rx_hit;
  logic              tmo;
  logic              waiting;
  logic              xfer;
  logic [IDX_W-1:0]  word_idx;
  logic [LANE_W-1:0] lane;

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mbx_lane_pick #(.NUM_LANES(NUM_LANES)) u_tx_pick (
    .flags (mb_tx_empty),
    .sel   (lane),
    .hit   (tx_hit)
  );

  mbx_lane_pick #(.NUM_LANES(NUM_LANES)) u_rx_pick (
    .flags (mb_rx_full),
    .sel   (lane),
    .hit   (rx_hit)
  );

  mbx_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (!waiting || xfer),
    .run     (waiting),
    .expired (tmo)
  );

  mbx_seq #(
    .DATA_W    (DATA_W),
    .NUM_LANES (NUM_LANES),
    .MAX_WORDS (MAX_WORDS),
    .SIZE_LSB  (SIZE_LSB),
    .SIZE_W    (SIZE_W),
    .RES_W     (RES_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start       (start),
    .no_resp     (no_resp),
    .buf_rd_data (buf_rd_data),
    .mb_rx_data  (mb_rx_data),
    .tx_hit      (tx_hit),
    .rx_hit      (rx_hit),
    .tmo         (tmo),
    .word_idx    (word_idx),
    .lane        (lane),
    .tx_we       (mb_tx_we),
    .rx_re       (mb_rx_re),
    .wr_en       (buf_wr_en),
    .wr_data     (buf_wr_data),
    .waiting     (waiting),
    .xfer        (xfer),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .result      (result)
  );

  assign buf_rd_idx = word_idx;
  assign buf_wr_idx = word_idx;
  assign mb_tx_sel  = lane;
  assign mb_rx_sel  = lane;
  assign mb_tx_data = buf_rd_data;

endmodule

// File: rtl/mbx_rpc_framer_chk.sv
module mbx_rpc_framer_chk #(
  parameter int NUM_LANES      = 4,
  parameter int TIMEOUT_CYCLES = 16,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [1:0]           err,
  input logic                 mb_tx_we,
  input logic [LANE_W-1:0]    mb_tx_sel,
  input logic [NUM_LANES-1:0] mb_tx_empty,
  input logic                 mb_rx_re,
  input logic [LANE_W-1:0]    mb_rx_sel,
  input logic [NUM_LANES-1:0] mb_rx_full
);

  logic [7:0]  tx_cnt;
  logic [7:0]  rx_cnt;
  logic [31:0] stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
      stall  <= '0;
    end else begin
      if (start && !busy) begin
        tx_cnt <= '0;
        rx_cnt <= '0;
      end else begin
        if (mb_tx_we) tx_cnt <= tx_cnt + 8'd1;
        if (mb_rx_re) rx_cnt <= rx_cnt + 8'd1;
      end
      if (busy && !done && !mb_tx_we && !mb_rx_re) begin
        stall <= stall + 32'd1;
      end else begin
        stall <= '0;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mb_tx_we && !mb_rx_re && !done));

  assert_tx_lane_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mb_tx_we |-> (mb_tx_sel == tx_cnt[LANE_W-1:0]));

  assert_rx_lane_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rx_re |-> (mb_rx_sel == rx_cnt[LANE_W-1:0]));

  assert_tx_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mb_tx_we |-> mb_tx_empty[mb_tx_sel]);

  assert_rx_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rx_re |-> mb_rx_full[mb_rx_sel]);

  assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stall <= 32'(TIMEOUT_CYCLES + 1)));

  assert_one_direction_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_tx_we && mb_rx_re));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err != 2'd3));

endmodule

bind mbx_rpc_framer mbx_rpc_framer_chk #(
  .NUM_LANES      (NUM_LANES),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .mb_tx_we    (mb_tx_we),
  .mb_tx_sel   (mb_tx_sel),
  .mb_tx_empty (mb_tx_empty),
  .mb_rx_re    (mb_rx_re),
  .mb_rx_sel   (mb_rx_sel),
  .mb_rx_full  (mb_rx_full)
);

// File: tb/sim_mbx_rpc_framer.sv
`timescale 1ns/1ps
module sim_mbx_rpc_framer;

  localparam int MAXW = 8;
  localparam int TMO  = 16;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        no_resp;
  logic        busy;
  logic        done;
  logic [1:0]  err;
  logic [7:0]  result;
  logic [3:0]  buf_rd_idx;
  logic [31:0] buf_rd_data;
  logic        buf_wr_en;
  logic [3:0]  buf_wr_idx;
  logic [31:0] buf_wr_data;
  logic [3:0]  mb_tx_empty;
  logic        mb_tx_we;
  logic [1:0]  mb_tx_sel;
  logic [31:0] mb_tx_data;
  logic [3:0]  mb_rx_full;
  logic        mb_rx_re;
  logic [1:0]  mb_rx_sel;
  logic [31:0] mb_rx_data;

  logic [31:0] txbuf [16];
  logic [31:0] resp  [16];
  logic [31:0] wbuf  [16];
  logic [1:0]  tx_lane [32];
  logic [31:0] tx_dat  [32];
  logic [1:0]  rx_lane [32];
  int tn, rn_log, wn, dn;
  int rp, rn;
  logic rx_on;
  logic rd_pend;
  int checks, fails;

  mbx_rpc_framer #(
    .MAX_WORDS      (MAXW),
    .TIMEOUT_CYCLES (TMO)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .no_resp     (no_resp),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .result      (result),
    .buf_rd_idx  (buf_rd_idx),
    .buf_rd_data (buf_rd_data),
    .buf_wr_en   (buf_wr_en),
    .buf_wr_idx  (buf_wr_idx),
    .buf_wr_data (buf_wr_data),
    .mb_tx_empty (mb_tx_empty),
    .mb_tx_we    (mb_tx_we),
    .mb_tx_sel   (mb_tx_sel),
    .mb_tx_data  (mb_tx_data),
    .mb_rx_full  (mb_rx_full),
    .mb_rx_re    (mb_rx_re),
    .mb_rx_sel   (mb_rx_sel),
    .mb_rx_data  (mb_rx_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign buf_rd_data = txbuf[buf_rd_idx];
  assign mb_rx_data  = resp[rp[3:0]];
  assign mb_rx_full  = (rx_on && rp < rn) ? (4'b0001 << rp[1:0]) : 4'b0000;

  always @(negedge clk) begin
    rd_pend = mb_rx_re;
    if (mb_tx_we && tn < 32) begin
      tx_lane[tn] = mb_tx_sel;
      tx_dat[tn]  = mb_tx_data;
      tn++;
    end
    if (mb_rx_re && rn_log < 32) begin
      rx_lane[rn_log] = mb_rx_sel;
      rn_log++;
    end
    if (buf_wr_en) begin
      wbuf[buf_wr_idx] = buf_wr_data;
      wn++;
    end
    if (done) dn++;
  end

  always @(posedge clk) begin
    if (rd_pend) rp <= rp + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    tn = 0; rn_log = 0; wn = 0; dn = 0; rp = 0; rn = 0;
    for (int i = 0; i < 16; i++) wbuf[i] = 32'hxxxx_xxxx;
  endtask

  task automatic call(input bit nr, output int cyc, output bit busy_seen,
                      output bit done_low_after);
    @(posedge clk); #1;
    start = 1'b1; no_resp = nr;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    busy_seen = 1'b0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) busy_seen = busy;
      if (done || cyc > 400) break;
    end
    @(negedge clk);
    done_low_after = !done;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mb_tx_we && !mb_rx_re && !buf_wr_en && err == 2'd0,
        "R1", "idle after reset", {busy, done, mb_tx_we, mb_rx_re, buf_wr_en, err}, 0);
  endtask

  task automatic t_tx_only();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'hA5A5_0300; txbuf[1] = 32'h1234_5678; txbuf[2] = 32'hDEAD_BEEF;
    call(1'b1, cyc, bs, dl);
    chk(tn == 3, "R3", "tx word count", tn, 3);
    for (int k = 0; k < 3; k++) begin
      chk(tx_lane[k] == 2'(k % 4) && tx_dat[k] == txbuf[k], "R2", "tx lane/data",
          {tx_lane[k], tx_dat[k][29:0]}, {2'(k % 4), txbuf[k][29:0]});
    end
    chk(rn_log == 0, "R8", "no reads with no_resp", rn_log, 0);
    chk(err == 2'd0, "R9", "err ok", err, 0);
    chk(result == 8'h78, "R10", "result from request word1", result, 8'h78);
    chk(bs && dl && dn == 1, "R9", "busy then single done", {bs, dl, 8'(dn)}, {2'b11, 8'd1});
  endtask

  task automatic t_round_trip();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h0000_0601;
    for (int k = 1; k < 6; k++) txbuf[k] = 32'h1000_0000 + k;
    resp[0] = 32'h00AB_0500;
    for (int k = 1; k < 5; k++) resp[k] = 32'hC0DE_0000 + 32'(k * 17);
    rn = 5; rx_on = 1'b1;
    call(1'b0, cyc, bs, dl);
    chk(tn == 6, "R2", "tx words round trip", tn, 6);
    for (int k = 0; k < 6; k++) begin
      chk(tx_lane[k] == 2'(k % 4), "R2", "tx lane wraps", tx_lane[k], 2'(k % 4));
    end
    chk(rn_log == 5, "R8", "reply read after request", rn_log, 5);
    for (int k = 0; k < 5; k++) begin
      chk(rx_lane[k] == 2'(k % 4) && wbuf[k] == resp[k], "R2", "rx lane/slot",
          wbuf[k], resp[k]);
    end
    chk(err == 2'd0, "R9", "err ok round trip", err, 0);
    chk(result == resp[1][7:0], "R10", "result from reply word1", result, resp[1][7:0]);
    rx_on = 1'b0;
  endtask

  task automatic t_size_zero();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h7700_0011; txbuf[1] = 32'hFFFF_FFFF;
    call(1'b1, cyc, bs, dl);
    chk(tn == 1, "R3", "size 0 sends header only", tn, 1);
    chk(result == 8'h00, "R10", "header-only result 0", result, 0);
  endtask

  task automatic t_size_max();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h0000_0800;
    for (int k = 1; k < 8; k++) txbuf[k] = 32'h5500_0000 + k;
    call(1'b1, cyc, bs, dl);
    chk(tn == 8 && err == 2'd0, "R4", "size equal to max accepted", {err, 8'(tn)}, {2'd0, 8'd8});
  endtask

  task automatic t_size_over_tx();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h0000_0900;
    call(1'b1, cyc, bs, dl);
    chk(tn == 0, "R4", "oversize writes nothing", tn, 0);
    chk(err == 2'd1, "R4", "oversize err", err, 1);
  endtask

  task automatic t_size_over_rx();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h0000_0100;
    resp[0] = 32'hFFFF_0C34; resp[1] = 32'h1111_1111; resp[2] = 32'h2222_2222;
    rn = 3; rx_on = 1'b1;
    call(1'b0, cyc, bs, dl);
    chk(rn_log == 1, "R5", "stop after bad reply header", rn_log, 1);
    chk(wbuf[0] == 32'h0, "R5", "slot0 cleared", wbuf[0], 0);
    chk(err == 2'd1, "R5", "reply length err", err, 1);
    rx_on = 1'b0;
  endtask

  task automatic t_stall();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h0000_0400;
    for (int k = 1; k < 4; k++) txbuf[k] = 32'h0A0A_0000 + k;
    mb_tx_empty = 4'b1011;
    @(posedge clk); #1;
    start = 1'b1; no_resp = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk(tn == 2 && busy, "R6", "held while register 2 full", tn, 2);
    @(posedge clk); #1;
    mb_tx_empty = 4'b1111;
    cyc = 0;
    while (!done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk(tn == 4 && tx_dat[2] == txbuf[2] && err == 2'd0, "R6", "resume after flag set",
        tn, 4);
  endtask

  task automatic t_tx_timeout();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h0000_0300;
    mb_tx_empty = 4'b1101;
    call(1'b1, cyc, bs, dl);
    chk(err == 2'd2, "R7", "tx timeout err", err, 2);
    chk(tn == 1, "R7", "no words after timeout", tn, 1);
    chk(cyc >= TMO && cyc <= TMO + 8, "R7", "timeout window", cyc, TMO);
    mb_tx_empty = 4'b1111;
  endtask

  task automatic t_rx_timeout();
    int cyc; bit bs, dl;
    clear_logs();
    txbuf[0] = 32'h0000_0100;
    rn = 0; rx_on = 1'b1;
    call(1'b0, cyc, bs, dl);
    chk(err == 2'd2, "R7", "reply timeout err", err, 2);
    chk(tn == 1 && rn_log == 0 && wn == 0, "R8", "reply phase waited", {8'(tn), 8'(wn)}, {8'd1, 8'd0});
    rx_on = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: call never finished actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    start = 1'b0; no_resp = 1'b0;
    mb_tx_empty = 4'b1111;
    rx_on = 1'b0; rd_pend = 1'b0;
    for (int i = 0; i < 16; i++) begin
      txbuf[i] = '0;
      resp[i]  = '0;
    end
    clear_logs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_only();
    t_round_trip();
    t_size_zero();
    t_size_max();
    t_size_over_tx();
    t_size_over_rx();
    t_stall();
    t_tx_timeout();
    t_rx_timeout();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule